// File: doc/BRIEF.md
# Programmable Video Sync Pulse Generator

This block shapes the master-mode sync outputs of a video encoder. An upstream line/field counter supplies a pixel clock, a one-clock line-start strobe and a one-clock field-start strobe. From these strobes and an 8-bit timing control word, the block drives an active-low horizontal sync and one combined field/vertical-sync output. It also delays the pixel data bus by 0 to 3 clocks relative to horizontal sync. Moving the bus by one clock changes which chroma sample lines up with the sync edge, so it can swap the order of the two chroma components.

The widths and delays are not linear counts. Each 2-bit field of the control word picks one entry from a fixed table. A mode input chooses between two behaviours for the combined output. In field mode it is a field level that toggles once per field. In vsync mode it is an active-low vertical sync pulse. Bits [5:4] of the control word mean different things in the two modes. The control word can be written and read back at any time. A new value is copied into the working copy only at the next line start, so a pulse that has already begun keeps its length.

Top module: `sync_pulse_gen`

## Requirements
- R1: `hsync_n` goes low on the clock after the edge that samples `line_start`. It stays low for a number of clocks set by control bits [1:0]: 00=1, 01=4, 10=16, 11=128.
- R2: For a falling field edge in field mode, and for every pulse in vsync mode, the combined output changes D clocks after `hsync_n` first reads low. D is set by bits [3:2]: 00=1, 01=3, 10=16, 11=64.
- R3: In vsync mode (`tmode_sel`=1), `fv_out` is low for a number of clocks set by bits [5:4]: 00=1, 01=4, 10=16, 11=64. It is high otherwise.
- R4: In field mode (`tmode_sel`=0), `fv_out` toggles once for each line start that carries `field_start`. A rising edge lands TB_CLKS clocks after `hsync_n` first reads low when bit 5 is 0, and TB_CLKS+OFF_CLKS clocks after it when bit 5 is 1. Bit 4 has no effect in this mode.
- R5: `pix_out` equals `pix_in` delayed by (code+1) clocks, where code is bits [7:6]. A code of 0 gives the same one-clock latency as `hsync_n`.
- R6: `cfg_rdata` shows the value written by `cfg_wr`/`cfg_wdata` from the clock after the write onward. It reads 0 after reset.
- R7: A control write takes effect only at the next line start. A pulse or delay already in progress uses the value that was loaded at its own line start.
- R8: While reset is held and after reset, `hsync_n` is 1, `pix_out` is 0, and `fv_out` is 0 in field mode or 1 in vsync mode.
- R9: A `field_start` without `line_start` is ignored. A line start without `field_start` leaves `fv_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| tmode_sel | input | 1 | 0: field level output, 1: vertical sync pulse output |
| cfg_wr | input | 1 | Write strobe for the timing control word |
| cfg_wdata | input | 8 | Timing control word to write |
| cfg_rdata | output | 8 | Readback of the timing control word |
| line_start | input | 1 | One-clock strobe at the start of each line |
| field_start | input | 1 | One-clock strobe, valid together with line_start on the first line of a field |
| pix_in | input | PIX_W | Incoming pixel data |
| hsync_n | output | 1 | Active-low horizontal sync |
| fv_out | output | 1 | Field level or active-low vertical sync |
| pix_out | output | PIX_W | Pixel data after the programmable delay |

## Verification
The bound checker watches, on every clock, four properties. Every falling edge of horizontal sync must follow a line start. The low phase of horizontal sync must never run past the longest table entry. The readback must follow writes and stay put without them. The zero-code pixel path must keep its one-clock latency. The exact widths and delays for every table code, the field toggle in both directions with and without the long offset, and the rule that a mid-line write waits for the next line all depend on a whole line's history. Only the bench scenarios show these, by measuring edge positions and counting low clocks within each line.

// File: rtl/sync_gen_pkg.sv
package sync_gen_pkg;

  typedef struct packed {
    logic [1:0] pix_adj;
    logic [1:0] v_ctl;
    logic [1:0] fv_dly;
    logic [1:0] hs_w;
  } tcfg_t;

  function automatic logic [7:0] hs_width(input logic [1:0] code);
    case (code)
      2'd0:    return 8'd1;
      2'd1:    return 8'd4;
      2'd2:    return 8'd16;
      default: return 8'd128;
    endcase
  endfunction

  function automatic logic [7:0] fv_delay(input logic [1:0] code);
    case (code)
      2'd0:    return 8'd1;
      2'd1:    return 8'd3;
      2'd2:    return 8'd16;
      default: return 8'd64;
    endcase
  endfunction

  function automatic logic [7:0] vs_width(input logic [1:0] code);
    case (code)
      2'd0:    return 8'd1;
      2'd1:    return 8'd4;
      2'd2:    return 8'd16;
      default: return 8'd64;
    endcase
  endfunction

endpackage

// File: rtl/sync_cfg_regs.sv
module sync_cfg_regs
  import sync_gen_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       line_start,
  output tcfg_t      shadow_q,
  output tcfg_t      active_q,
  output logic [7:0] rd_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      if (wr_en)      shadow_q <= tcfg_t'(wr_data);
      if (line_start) active_q <= shadow_q;
    end
  end

  assign rd_data = shadow_q;

endmodule

// File: rtl/sync_hpulse.sv
module sync_hpulse
  import sync_gen_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       line_start,
  input  logic [1:0] width_code,
  output logic       hsync_n
);

  logic [7:0] rem_q, rem_d;

  always_comb begin
    if (line_start)        rem_d = hs_width(width_code);
    else if (rem_q != '0)  rem_d = rem_q - 8'd1;
    else                   rem_d = rem_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q   <= '0;
      hsync_n <= 1'b1;
    end else begin
      rem_q   <= rem_d;
      hsync_n <= (rem_d == '0);
    end
  end

endmodule

// File: rtl/sync_vfield.sv
module sync_vfield
  import sync_gen_pkg::*;
#(
  parameter int TB_CLKS  = 24,
  parameter int OFF_CLKS = 864
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  line_start,
  input  logic  field_start,
  input  logic  tmode_sel,
  input  tcfg_t shadow_cfg,
  input  tcfg_t active_cfg,
  output logic  fv_out
);

  localparam int DW = $clog2(TB_CLKS + OFF_CLKS + 64 + 1) + 1;

  logic [DW-1:0] dcnt_q, dcnt_d, dly_load;
  logic          pend_q, pend_d;
  logic [7:0]    vrem_q, vrem_d;
  logic          field_q, field_d;
  logic          vsn_q, vsn_d;
  logic          start_fld, fire;

  assign start_fld = line_start && field_start;

  always_comb begin
    if (!tmode_sel && !field_q) begin
      dly_load = DW'(TB_CLKS);
      if (shadow_cfg.v_ctl[1]) dly_load = DW'(TB_CLKS + OFF_CLKS);
    end else begin
      dly_load = DW'(fv_delay(shadow_cfg.fv_dly));
    end
  end

  assign fire = pend_q && (dcnt_q == '0) && !start_fld;

  always_comb begin
    dcnt_d = dcnt_q;
    pend_d = pend_q;
    if (start_fld) begin
      dcnt_d = dly_load - DW'(1);
      pend_d = 1'b1;
    end else if (pend_q) begin
      if (dcnt_q == '0) pend_d = 1'b0;
      else              dcnt_d = dcnt_q - DW'(1);
    end
  end

  always_comb begin
    field_d = field_q;
    if (fire && !tmode_sel) field_d = ~field_q;
  end

  always_comb begin
    vrem_d = vrem_q;
    vsn_d  = 1'b1;
    if (fire && tmode_sel) begin
      vrem_d = vs_width(active_cfg.v_ctl);
      vsn_d  = 1'b0;
    end else if (vrem_q != '0) begin
      vrem_d = vrem_q - 8'd1;
      vsn_d  = (vrem_d == '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dcnt_q  <= '0;
      pend_q  <= 1'b0;
      vrem_q  <= '0;
      field_q <= 1'b0;
      vsn_q   <= 1'b1;
      fv_out  <= tmode_sel;
    end else begin
      dcnt_q  <= dcnt_d;
      pend_q  <= pend_d;
      vrem_q  <= vrem_d;
      field_q <= field_d;
      vsn_q   <= vsn_d;
      fv_out  <= tmode_sel ? vsn_d : field_d;
    end
  end

endmodule

// File: rtl/sync_pix_delay.sv
module sync_pix_delay #(
  parameter int PIX_W  = 10,
  parameter int STAGES = 3
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [$clog2(STAGES+1)-1:0]     sel,
  input  logic [PIX_W-1:0]                pix_in,
  output logic [PIX_W-1:0]                pix_out
);

  logic [PIX_W-1:0] tap [0:STAGES];

  assign tap[0] = pix_in;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) tap[i+1] <= '0;
      else     tap[i+1] <= tap[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pix_out <= '0;
    else     pix_out <= tap[sel];
  end

endmodule

// File: rtl/sync_pulse_gen.sv
module sync_pulse_gen
  import sync_gen_pkg::*;
#(
  parameter int PIX_W    = 10,
  parameter int TB_CLKS  = 24,
  parameter int OFF_CLKS = 864
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tmode_sel,
  input  logic             cfg_wr,
  input  logic [7:0]       cfg_wdata,
  output logic [7:0]       cfg_rdata,
  input  logic             line_start,
  input  logic             field_start,
  input  logic [PIX_W-1:0] pix_in,
  output logic             hsync_n,
  output logic             fv_out,
  output logic [PIX_W-1:0] pix_out
);

  localparam int PIX_STAGES = 3;

  tcfg_t      shadow_cfg, active_cfg;
  logic [1:0] pix_code;

  sync_cfg_regs u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (cfg_wr),
    .wr_data   (cfg_wdata),
    .line_start(line_start),
    .shadow_q  (shadow_cfg),
    .active_q  (active_cfg),
    .rd_data   (cfg_rdata)
  );

  sync_hpulse u_hs (
    .clk       (clk),
    .rst       (rst),
    .line_start(line_start),
    .width_code(shadow_cfg.hs_w),
    .hsync_n   (hsync_n)
  );

  sync_vfield #(
    .TB_CLKS (TB_CLKS),
    .OFF_CLKS(OFF_CLKS)
  ) u_vf (
    .clk        (clk),
    .rst        (rst),
    .line_start (line_start),
    .field_start(field_start),
    .tmode_sel  (tmode_sel),
    .shadow_cfg (shadow_cfg),
    .active_cfg (active_cfg),
    .fv_out     (fv_out)
  );

  assign pix_code = active_cfg.pix_adj;

  sync_pix_delay #(
    .PIX_W (PIX_W),
    .STAGES(PIX_STAGES)
  ) u_pix (
    .clk    (clk),
    .rst    (rst),
    .sel    (pix_code),
    .pix_in (pix_in),
    .pix_out(pix_out)
  );

endmodule

// File: rtl/sync_pulse_gen_chk.sv
module sync_pulse_gen_chk #(
  parameter int PIX_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             line_start,
  input logic             cfg_wr,
  input logic [7:0]       cfg_wdata,
  input logic [7:0]       cfg_rdata,
  input logic             hsync_n,
  input logic [PIX_W-1:0] pix_in,
  input logic [PIX_W-1:0] pix_out,
  input logic [1:0]       pix_code
);

  logic [8:0] low_run;

  always_ff @(posedge clk) begin
    if (rst)           low_run <= '0;
    else if (!hsync_n) low_run <= low_run + 9'd1;
    else               low_run <= '0;
  end

  assert_hsync_after_line_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(hsync_n) |-> $past(line_start));

  assert_hsync_max_width_R1: assert property (@(posedge clk) disable iff (rst)
    low_run <= 9'd128);

  assert_cfg_readback_R6: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |=> (cfg_rdata == $past(cfg_wdata)));

  assert_cfg_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !cfg_wr |=> $stable(cfg_rdata));

  assert_pix_zero_code_R5: assert property (@(posedge clk) disable iff (rst)
    (pix_code == 2'd0) |=> (pix_out == $past(pix_in)));

endmodule

bind sync_pulse_gen sync_pulse_gen_chk #(.PIX_W(PIX_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .line_start(line_start),
  .cfg_wr    (cfg_wr),
  .cfg_wdata (cfg_wdata),
  .cfg_rdata (cfg_rdata),
  .hsync_n   (hsync_n),
  .pix_in    (pix_in),
  .pix_out   (pix_out),
  .pix_code  (pix_code)
);

// File: tb/tb_sync_pulse_gen.sv
module tb_sync_pulse_gen;

  localparam int CLK_PERIOD = 10;
  localparam int PIX_W      = 10;
  localparam int TB_CLKS    = 24;
  localparam int OFF_CLKS   = 864;
  localparam int LINE_LEN   = 1000;

  logic             clk = 1'b0;
  logic             rst;
  logic             tmode_sel;
  logic             cfg_wr;
  logic [7:0]       cfg_wdata;
  logic [7:0]       cfg_rdata;
  logic             line_start;
  logic             field_start;
  logic [PIX_W-1:0] pix_in;
  logic             hsync_n;
  logic             fv_out;
  logic [PIX_W-1:0] pix_out;

  int n_checks = 0;
  int n_fails  = 0;

  int hs_first, hs_len, fv_chg, fv_low, pix_bad;
  logic [PIX_W-1:0] hist [0:15];

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_pulse_gen #(
    .PIX_W   (PIX_W),
    .TB_CLKS (TB_CLKS),
    .OFF_CLKS(OFF_CLKS)
  ) dut (
    .clk        (clk),
    .rst        (rst),
    .tmode_sel  (tmode_sel),
    .cfg_wr     (cfg_wr),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .line_start (line_start),
    .field_start(field_start),
    .pix_in     (pix_in),
    .hsync_n    (hsync_n),
    .fv_out     (fv_out),
    .pix_out    (pix_out)
  );

  function automatic int exp_hs(input logic [1:0] c);
    int t [4] = '{1, 4, 16, 128};
    return t[c];
  endfunction

  function automatic int exp_dly(input logic [1:0] c);
    int t [4] = '{1, 3, 16, 64};
    return t[c];
  endfunction

  function automatic int exp_vw(input logic [1:0] c);
    int t [4] = '{1, 4, 16, 64};
    return t[c];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  task automatic write_cfg(input logic [7:0] v);
    @(negedge clk);
    cfg_wr = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_wr = 1'b0;
    chk(cfg_rdata == v, "R6 readback", cfg_rdata, v);
  endtask

  // One line: index k is the value seen after the k-th edge following the strobe edge.
  task automatic run_line(input logic fs, input int n, input logic [1:0] pcode,
                          input int wr_at, input logic [7:0] wr_val);
    logic fv_prev;
    @(negedge clk);
    fv_prev = fv_out;
    hs_first = -1; hs_len = 0; fv_chg = -1; fv_low = 0; pix_bad = 0;
    line_start = 1'b1;
    field_start = fs;
    pix_in = PIX_W'($urandom);
    hist[0] = pix_in;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      line_start = 1'b0;
      field_start = 1'b0;
      cfg_wr = 1'b0;
      if (!hsync_n) begin
        if (hs_first < 0) hs_first = k;
        hs_len++;
      end
      if (fv_out != fv_prev && fv_chg < 0) fv_chg = k;
      if (!fv_out) fv_low++;
      if (k >= 4 && k < 12 && pix_out != hist[k - int'(pcode)]) pix_bad++;
      if (k == wr_at) begin
        cfg_wr = 1'b1;
        cfg_wdata = wr_val;
      end
      pix_in = PIX_W'($urandom);
      if (k + 1 < 16) hist[k+1] = pix_in;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic       fld;
    int         e;
    void'($urandom(32'd4242));
    rst = 1'b1; tmode_sel = 1'b0; cfg_wr = 1'b0; cfg_wdata = '0;
    line_start = 1'b0; field_start = 1'b0; pix_in = '0;
    repeat (5) @(negedge clk);
    chk(hsync_n == 1'b1 && fv_out == 1'b0 && pix_out == '0, "R8 reset outputs",
        {hsync_n, fv_out}, 2);
    rst = 1'b0;
    @(negedge clk);
    chk(cfg_rdata == 8'd0, "R6 reset readback", cfg_rdata, 0);
    chk(hsync_n == 1'b1 && fv_out == 1'b0, "R8 after reset", {hsync_n, fv_out}, 2);

    // R1 widths, R9 no field change, R5 pixel delay
    for (int c = 0; c < 4; c++) begin
      v = {2'($urandom), 4'($urandom), 2'(c)};
      write_cfg(v);
      run_line(1'b0, 200, v[7:6], -1, 8'd0);
      chk(hs_first == 0, "R1 hsync start", hs_first, 0);
      chk(hs_len == exp_hs(2'(c)), "R1 hsync width", hs_len, exp_hs(2'(c)));
      chk(fv_chg < 0, "R9 no field start", fv_chg, -1);
      chk(pix_bad == 0, "R5 pixel delay", pix_bad, 0);
    end

    // R4 / R2 field mode: directed then random
    fld = 1'b0;
    for (int i = 0; i < 10; i++) begin
      case (i)
        0: v = 8'b00_00_00_01;
        1: v = 8'b01_00_11_00;
        2: v = 8'b10_11_00_10;
        3: v = 8'b11_01_00_00;
        4: v = 8'b00_01_10_00;
        5: v = 8'b00_00_01_11;
        default: v = 8'($urandom);
      endcase
      write_cfg(v);
      if (!fld) e = TB_CLKS + (v[5] ? OFF_CLKS : 0);
      else      e = exp_dly(v[3:2]);
      run_line(1'b1, LINE_LEN, v[7:6], -1, 8'd0);
      fld = ~fld;
      chk(fv_chg == e, fld ? "R4 field rise" : "R2 field fall", fv_chg, e);
      chk(fv_out == fld, "R4 field level", fv_out, fld);
      chk(pix_bad == 0, "R5 pixel delay", pix_bad, 0);
    end

    // R9: field_start alone is ignored
    @(negedge clk);
    field_start = 1'b1;
    @(negedge clk);
    field_start = 1'b0;
    repeat (LINE_LEN) @(negedge clk);
    chk(fv_out == fld, "R9 lone field_start", fv_out, fld);

    // Vsync mode
    @(negedge clk);
    tmode_sel = 1'b1;
    repeat (3) @(negedge clk);
    chk(fv_out == 1'b1, "R3 vsync idle high", fv_out, 1);
    for (int d = 0; d < 4; d++) begin
      for (int w = 0; w < 4; w++) begin
        v = {2'($urandom), 2'(w), 2'(d), 2'($urandom)};
        write_cfg(v);
        run_line(1'b1, 200, v[7:6], -1, 8'd0);
        chk(fv_chg == exp_dly(2'(d)), "R2 vsync delay", fv_chg, exp_dly(2'(d)));
        chk(fv_low == exp_vw(2'(w)), "R3 vsync width", fv_low, exp_vw(2'(w)));
        chk(hs_len == exp_hs(v[1:0]), "R1 hsync width", hs_len, exp_hs(v[1:0]));
      end
    end

    // R7: mid-line write waits for next line
    write_cfg(8'b00_10_01_11);
    run_line(1'b1, 200, 2'd0, 1, 8'b00_00_00_00);
    chk(hs_len == 128, "R7 hsync kept", hs_len, 128);
    chk(fv_chg == 3, "R7 delay kept", fv_chg, 3);
    chk(fv_low == 16, "R7 vsync width kept", fv_low, 16);
    chk(cfg_rdata == 8'd0, "R6 readback mid-line write", cfg_rdata, 0);
    run_line(1'b1, 200, 2'd0, -1, 8'd0);
    chk(hs_len == 1, "R7 new hsync", hs_len, 1);
    chk(fv_chg == 1, "R7 new delay", fv_chg, 1);
    chk(fv_low == 1, "R7 new vsync width", fv_low, 1);

    summary();
    $finish;
  end

endmodule